// File: doc/BRIEF.md
# Output Offset Trim Sequencer

This block runs on the controller side of an analog playback front end and trims the output offset of one channel at a time. On a start request it puts the front end into monitor mode for the chosen channel, then moves a digital offset code by one step per register write. After each write it waits a programmable settling time and then reads a one-bit polarity monitor. The search ends when the monitor polarity differs from the polarity it first read. The code at that point is the trimmed value. It is written to the front end once more with monitor mode released, and it is stored in a result table.

The table holds one code for each head of each channel. When the tape transport switches heads, a reload request makes the block write the stored codes for the new head into every channel, channel A first. Every write to the front end is a single request/acknowledge handshake. The code range is clamped. If the search would step past either end of the range, the search stops and an error flag is raised.

Top module: `ocal_seq`

## Requirements
- R1: After reset, busy, done, err and wr_req are low, and every table entry and each channel's current code hold DEFAULT_CODE.
- R2: An accepted start issues a first write with wr_mon = 1 and wr_chan equal to the requested channel (0 = channel A, 1 = channel B).
- R3: wr_req stays high, with wr_mon, wr_chan and wr_code unchanged, until the cycle in which wr_ack is high. Exactly one write completes per such cycle.
- R4: The monitor is sampled only after a monitored write has been acknowledged and settle_cycles + 1 further cycles have passed. The next write request comes no earlier than the cycle after that sample.
- R5: If the monitor reads low, the next write carries the code one below the last one. If it reads high, the next write carries the code one above. Each write changes the code by exactly one step.
- R6: The search stops at the first monitor reading whose polarity differs from the first reading. That code is then written with wr_mon = 0 and stored in table_o at entry chan*NUM_HD + head, which occupies bits [entry*CODE_W +: CODE_W].
- R7: A search starts from the channel's current code. This is DEFAULT_CODE after reset, or otherwise the last code written to that channel by any write.
- R8: If a step would go below 0 or above 2^CODE_W - 1, the search stops and err goes high. The limit code is written with wr_mon = 0, and the table is not changed. err clears at the next accepted start.
- R9: A reload request with head h issues one write per channel, in rising channel order, each with wr_mon = 0 and the stored code for that channel and head h. These codes become the channels' current codes.
- R10: busy rises in the cycle after an accepted start or reload and falls in the cycle after the one-cycle done pulse. start and reload are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_cycles | input | SETTLE_W | Extra settling cycles after each monitored write |
| start | input | 1 | Start a trim search |
| start_chan | input | CH_W | Channel to trim |
| start_head | input | HD_W | Head the result belongs to |
| reload | input | 1 | Reload stored codes after a head switch |
| reload_head | input | HD_W | New head for the reload |
| monitor | input | 1 | Offset polarity monitor from the front end |
| wr_req | output | 1 | Register write request |
| wr_mon | output | 1 | Monitor-mode bit of the write |
| wr_chan | output | CH_W | Channel the write addresses |
| wr_code | output | CODE_W | Offset code of the write |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last search hit a code limit |
| table_o | output | NUM_CH*NUM_HD*CODE_W | Stored codes, entry chan*NUM_HD+head |

## Verification
The bench sweeps the monitor threshold over every code and one past each end, on both channels and both heads, and lets each search start from wherever the previous one left the code. This covers both search directions and both clamp limits, so a design with a wrong step sign would wander to a limit, and one without clamping would wrap around. The modelled monitor shows the inverted, stale polarity until exactly settle_cycles + 1 cycles after the acknowledge. A design that samples one cycle early therefore stops at the wrong code or runs into a limit. Reloads, start pulses during a busy search, and acknowledges delayed by several cycles check that the current code follows the last write, and that a second start does not take over the search.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_WR,
      S_SETTLE,
      S_EVAL,
      S_DONE
   } ocal_state_e;

   typedef enum logic [1:0] {
      OP_FIRST,
      OP_STEP,
      OP_RELEASE,
      OP_RELOAD
   } ocal_op_e;
endpackage

// File: rtl/ocal_step.sv
module ocal_step #(
   parameter int CODE_W = 6
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              up_i,
   output logic [CODE_W-1:0] next_o,
   output logic              limit_o
);
   localparam logic [CODE_W-1:0] CODE_TOP = '1;

   always_comb begin
      limit_o = up_i ? (code_i == CODE_TOP) : (code_i == '0);
      next_o  = up_i ? code_i + 1'b1 : code_i - 1'b1;
   end
endmodule

// File: rtl/ocal_settle.sv
module ocal_settle #(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [SETTLE_W-1:0] val_i,
   output logic                zero_o
);
   logic [SETTLE_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ocal_table.sv
module ocal_table #(
   parameter int CODE_W       = 6,
   parameter int ENTRIES      = 4,
   parameter int IDX_W        = 2,
   parameter int DEFAULT_CODE = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [CODE_W-1:0]         data_i,
   output logic [ENTRIES*CODE_W-1:0] flat_o
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [CODE_W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent_q <= CODE_W'(DEFAULT_CODE);
         else if (we_i && (idx_i == IDX_W'(e)))
            ent_q <= data_i;
      end
      assign flat_o[e*CODE_W +: CODE_W] = ent_q;
   end
endmodule

// File: rtl/ocal_seq.sv
module ocal_seq
   import ocal_pkg::*;
#(
   parameter int CODE_W       = 6,
   parameter int SETTLE_W     = 8,
   parameter int NUM_CH       = 2,
   parameter int NUM_HD       = 2,
   parameter int DEFAULT_CODE = 1 << (CODE_W - 1),
   localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int HD_W        = (NUM_HD > 1) ? $clog2(NUM_HD) : 1,
   localparam int ENTRIES     = NUM_CH * NUM_HD,
   localparam int IDX_W       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [SETTLE_W-1:0]       settle_cycles,
   input  logic                      start,
   input  logic [CH_W-1:0]           start_chan,
   input  logic [HD_W-1:0]           start_head,
   input  logic                      reload,
   input  logic [HD_W-1:0]           reload_head,
   input  logic                      monitor,
   output logic                      wr_req,
   output logic                      wr_mon,
   output logic [CH_W-1:0]           wr_chan,
   output logic [CODE_W-1:0]         wr_code,
   input  logic                      wr_ack,
   output logic                      busy,
   output logic                      done,
   output logic                      err,
   output logic [ENTRIES*CODE_W-1:0] table_o
);
   if (CODE_W < 2)
      $error("ocal_seq: CODE_W must be at least 2");
   if (NUM_CH < 2 || NUM_HD < 1)
      $error("ocal_seq: need two or more channels and one or more heads");
   if (DEFAULT_CODE < 0 || DEFAULT_CODE >= (1 << CODE_W))
      $error("ocal_seq: DEFAULT_CODE outside the code range");
   if (SETTLE_W < 1)
      $error("ocal_seq: SETTLE_W must be positive");

   ocal_state_e       state_q;
   ocal_op_e          op_q;
   logic [CH_W-1:0]   ch_q;
   logic [HD_W-1:0]   hd_q;
   logic [CODE_W-1:0] code_q;
   logic              ref_q;
   logic              err_q;
   logic [CODE_W-1:0] cur_q [NUM_CH];

   logic [CODE_W-1:0] step_next;
   logic              step_limit;
   logic              settle_zero;
   logic              settle_load;
   logic              tbl_we;
   logic [IDX_W-1:0]  tbl_idx;

   function automatic logic [CODE_W-1:0] entry_of(input int ch, input int hd);
      return table_o[(ch * NUM_HD + hd) * CODE_W +: CODE_W];
   endfunction

   ocal_step #(.CODE_W(CODE_W)) u_step (
      .code_i  (code_q),
      .up_i    (monitor),
      .next_o  (step_next),
      .limit_o (step_limit)
   );

   assign settle_load = (state_q == S_WR) && wr_ack &&
                        ((op_q == OP_FIRST) || (op_q == OP_STEP));

   ocal_settle #(.SETTLE_W(SETTLE_W)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (settle_load),
      .val_i  (settle_cycles),
      .zero_o (settle_zero)
   );

   assign tbl_we  = (state_q == S_DONE) && (op_q == OP_RELEASE) && !err_q;
   assign tbl_idx = IDX_W'(int'(ch_q) * NUM_HD + int'(hd_q));

   ocal_table #(
      .CODE_W       (CODE_W),
      .ENTRIES      (ENTRIES),
      .IDX_W        (IDX_W),
      .DEFAULT_CODE (DEFAULT_CODE)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (tbl_we),
      .idx_i  (tbl_idx),
      .data_i (code_q),
      .flat_o (table_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_q    <= OP_FIRST;
         ch_q    <= '0;
         hd_q    <= '0;
         code_q  <= CODE_W'(DEFAULT_CODE);
         ref_q   <= 1'b0;
         err_q   <= 1'b0;
         for (int c = 0; c < NUM_CH; c++) cur_q[c] <= CODE_W'(DEFAULT_CODE);
      end else begin
         case (state_q)
            S_IDLE: begin
               if (start) begin
                  ch_q    <= start_chan;
                  hd_q    <= start_head;
                  code_q  <= cur_q[start_chan];
                  op_q    <= OP_FIRST;
                  err_q   <= 1'b0;
                  state_q <= S_WR;
               end else if (reload) begin
                  ch_q    <= '0;
                  hd_q    <= reload_head;
                  code_q  <= entry_of(0, int'(reload_head));
                  op_q    <= OP_RELOAD;
                  state_q <= S_WR;
               end
            end
            S_WR: begin
               if (wr_ack) begin
                  cur_q[ch_q] <= code_q;
                  case (op_q)
                     OP_FIRST, OP_STEP: state_q <= S_SETTLE;
                     OP_RELEASE:        state_q <= S_DONE;
                     default: begin
                        if (ch_q == CH_W'(NUM_CH - 1)) begin
                           state_q <= S_DONE;
                        end else begin
                           ch_q   <= ch_q + 1'b1;
                           code_q <= entry_of(int'(ch_q) + 1, int'(hd_q));
                        end
                     end
                  endcase
               end
            end
            S_SETTLE: begin
               if (settle_zero) state_q <= S_EVAL;
            end
            S_EVAL: begin
               state_q <= S_WR;
               if (op_q == OP_FIRST) ref_q <= monitor;
               if ((op_q != OP_FIRST) && (monitor != ref_q)) begin
                  op_q <= OP_RELEASE;
               end else if (step_limit) begin
                  err_q <= 1'b1;
                  op_q  <= OP_RELEASE;
               end else begin
                  code_q <= step_next;
                  op_q   <= OP_STEP;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign wr_req  = (state_q == S_WR);
   assign wr_mon  = (op_q == OP_FIRST) || (op_q == OP_STEP);
   assign wr_chan = ch_q;
   assign wr_code = code_q;
   assign busy    = (state_q != S_IDLE);
   assign done    = (state_q == S_DONE);
   assign err     = err_q;
endmodule

// File: rtl/ocal_seq_chk.sv
module ocal_seq_chk #(
   parameter int CODE_W   = 6,
   parameter int SETTLE_W = 8,
   parameter int CH_W     = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SETTLE_W-1:0] settle_cycles,
   input logic                start,
   input logic                wr_req,
   input logic                wr_mon,
   input logic [CH_W-1:0]     wr_chan,
   input logic [CODE_W-1:0]   wr_code,
   input logic                wr_ack,
   input logic                busy,
   input logic                done,
   input logic                err
);
   logic                trk_q;
   logic [SETTLE_W+1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trk_q <= 1'b0;
         gap_q <= '0;
      end else if (wr_req && wr_ack && wr_mon) begin
         trk_q <= 1'b1;
         gap_q <= '0;
      end else if (trk_q && wr_req) begin
         trk_q <= 1'b0;
      end else if (trk_q) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R3
   a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req && !wr_ack |=> wr_req && $stable(wr_code) && $stable(wr_mon) && $stable(wr_chan));

   // R4
   a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      trk_q && wr_req |-> gap_q >= ({2'b00, settle_cycles} + 2));

   // R10
   a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_req);

   a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);

   a_r10_done_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R8
   a_r8_err_in_search: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> busy);
endmodule

bind ocal_seq ocal_seq_chk #(
   .CODE_W   (CODE_W),
   .SETTLE_W (SETTLE_W),
   .CH_W     (CH_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .settle_cycles (settle_cycles),
   .start         (start),
   .wr_req        (wr_req),
   .wr_mon        (wr_mon),
   .wr_chan       (wr_chan),
   .wr_code       (wr_code),
   .wr_ack        (wr_ack),
   .busy          (busy),
   .done          (done),
   .err           (err)
);

// File: tb/sim_ocal_seq.sv
module sim_ocal_seq;
   localparam int CW   = 4;
   localparam int SW   = 4;
   localparam int NC   = 2;
   localparam int NH   = 2;
   localparam int DEF  = 8;
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [SW-1:0] settle_cycles = '0;
   logic          start = 1'b0;
   logic          start_chan = 1'b0;
   logic          start_head = 1'b0;
   logic          reload = 1'b0;
   logic          reload_head = 1'b0;
   logic          monitor = 1'b0;
   logic          wr_req, wr_mon, wr_chan, wr_ack = 1'b0;
   logic [CW-1:0] wr_code;
   logic          busy, done, err;
   logic [NC*NH*CW-1:0] table_o;

   ocal_seq #(.CODE_W(CW), .SETTLE_W(SW), .NUM_CH(NC), .NUM_HD(NH), .DEFAULT_CODE(DEF)) u0 (
      .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
      .start(start), .start_chan(start_chan), .start_head(start_head),
      .reload(reload), .reload_head(reload_head), .monitor(monitor),
      .wr_req(wr_req), .wr_mon(wr_mon), .wr_chan(wr_chan), .wr_code(wr_code),
      .wr_ack(wr_ack), .busy(busy), .done(done), .err(err), .table_o(table_o)
   );

   // front-end model
   int   thr [NC];
   int   ack_wait = 0;
   int   wcnt = 0;
   int   lag = 0;
   logic mon_new = 1'b0;
   logic log_clr = 1'b0;
   int   nlog = 0;
   int   log_code [64];
   logic log_mon  [64];
   logic log_chan [64];
   logic hv = 1'b0;
   logic [CW-1:0] hc = '0;
   int   viol = 0;

   always @(posedge clk) begin
      if (hv && (!wr_req || wr_code != hc)) viol <= viol + 1;
      hv <= wr_req && !wr_ack;
      hc <= wr_code;
      if (log_clr) nlog <= 0;
      if (wr_req && wr_ack) begin
         if (nlog < 64 && !log_clr) begin
            log_code[nlog] <= int'(wr_code);
            log_mon[nlog]  <= wr_mon;
            log_chan[nlog] <= wr_chan;
            nlog <= nlog + 1;
         end
         if (wr_mon) begin
            lag     <= int'(settle_cycles) + 1;
            mon_new <= (int'(wr_code) < thr[wr_chan]);
            monitor <= !(int'(wr_code) < thr[wr_chan]);
         end
         wr_ack <= 1'b0;
         wcnt   <= 0;
      end else begin
         if (wr_req) begin
            if (wcnt >= ack_wait) wr_ack <= 1'b1;
            else wcnt <= wcnt + 1;
         end
         if (lag != 0) begin
            lag <= lag - 1;
            if (lag == 1) monitor <= mon_new;
         end
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   bit fin = 1'b0;
   int mcur [NC];
   int mtbl [NC][NH];

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int tbl_at(input int c, input int h);
      return int'(table_o[(c * NH + h) * CW +: CW]);
   endfunction

   task automatic clear_log();
      @(negedge clk) log_clr = 1'b1;
      @(negedge clk) log_clr = 1'b0;
   endtask

   task automatic wait_done(input string rq);
      int k = 0;
      while (!done && k < 3000) begin
         @(negedge clk);
         k++;
      end
      chk(rq, int'(done), 1);
   endtask

   task automatic run_cal(input int ch, input int hd, input int t, input int st,
                          input int aw, input bit poke);
      int c0, res, steps;
      bit up, xerr, dir_ok, ch_ok;
      thr[ch] = t;
      settle_cycles = SW'(st);
      ack_wait = aw;
      clear_log();
      c0 = mcur[ch];
      up = (c0 < t);
      if (up) begin
         xerr = (t > MAXC);
         res  = xerr ? MAXC : t;
         steps = res - c0;
      end else begin
         xerr = (t == 0);
         res  = xerr ? 0 : t - 1;
         steps = c0 - res;
      end
      start_chan = ch[0];
      start_head = hd[0];
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R10 busy after start", int'(busy), 1);
      if (poke) begin
         repeat (3) @(negedge clk);
         start_chan = ~ch[0];
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      wait_done("R10 done pulse");
      @(negedge clk);
      chk("R10 busy low after done", int'(busy), 0);
      chk("R2 first write monitor bit", int'(log_mon[0]), 1);
      chk("R2 first write channel", int'(log_chan[0]), ch);
      chk("R7 start code", log_code[0], c0);
      chk("R5 write count", nlog, steps + 2);
      dir_ok = 1'b1;
      ch_ok  = 1'b1;
      for (int i = 1; i < nlog - 1; i++)
         if (log_code[i] != log_code[i-1] + (up ? 1 : -1)) dir_ok = 1'b0;
      for (int i = 0; i < nlog; i++)
         if (log_chan[i] != ch[0]) ch_ok = 1'b0;
      chk("R5 single steps in monitor direction", int'(dir_ok), 1);
      chk("R10 no foreign-channel write", int'(ch_ok), 1);
      chk("R6 final code", log_code[nlog-1], res);
      chk("R6 final write releases monitor", int'(log_mon[nlog-1]), 0);
      chk("R8 error flag", int'(err), int'(xerr));
      if (!xerr) mtbl[ch][hd] = res;
      mcur[ch] = res;
      for (int c = 0; c < NC; c++)
         for (int h = 0; h < NH; h++)
            chk("R6 table entry", tbl_at(c, h), mtbl[c][h]);
      if (poke) begin
         repeat (3) @(negedge clk);
         chk("R10 start during busy ignored", int'(busy), 0);
      end
   endtask

   task automatic run_reload(input int h, input int aw);
      ack_wait = aw;
      clear_log();
      reload_head = h[0];
      reload = 1'b1;
      @(negedge clk) reload = 1'b0;
      wait_done("R9 reload done");
      @(negedge clk);
      chk("R9 reload write count", nlog, NC);
      for (int c = 0; c < NC; c++) begin
         chk("R9 reload channel order", int'(log_chan[c]), c);
         chk("R9 reload monitor bit", int'(log_mon[c]), 0);
         chk("R9 reload code", log_code[c], mtbl[c][h]);
         mcur[c] = mtbl[c][h];
      end
   endtask

   initial begin
      for (int c = 0; c < NC; c++) begin
         thr[c] = 0;
         mcur[c] = DEF;
         for (int h = 0; h < NH; h++) mtbl[c][h] = DEF;
      end
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 wr_req", int'(wr_req), 0);
      chk("R1 err", int'(err), 0);
      chk("R1 done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < NC; c++)
         for (int h = 0; h < NH; h++)
            chk("R1 table default", tbl_at(c, h), DEF);

      for (int t = 0; t <= MAXC + 1; t++) run_cal(0, 0, t, 3, 0, 1'b0);
      for (int t = MAXC + 1; t >= 0; t--) run_cal(1, 1, t, 0, 2, 1'b0);
      for (int t = 2; t <= MAXC; t += 3) run_cal(0, 1, t, 7, 1, 1'b0);
      for (int t = MAXC; t >= 1; t -= 4) run_cal(1, 0, t, 15, 0, 1'b0);
      run_reload(0, 1);
      run_cal(1, 0, 5, 2, 0, 1'b0);
      run_reload(1, 0);
      run_cal(0, 1, 11, 1, 3, 1'b1);
      run_cal(1, 1, 0, 4, 0, 1'b1);
      run_reload(0, 2);

      chk("R3 fields held until ack", viol, 0);
      if (!fin) begin
         fin = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule